// File: doc/BRIEF.md
# Prioritized Serial-Port Interrupt Controller

This block collects every interrupt source of one serial-port channel, gates each through an enable vector, and reports the most urgent pending source as a six-bit status code together with a single request line. Sources arrive as one-cycle event strobes or as levels from the neighbouring receive FIFO, transmit FIFO, line-error, modem-line, flow-control and character-match logic. Register-access strobes from the bus side serve as clear events. These are the reads of the status, line-status, modem-status and receive-data registers, and the write of the transmit-data register.

Event-type sources are held in sticky flags until their own clear rule fires. The receive-ready source is a pure level that follows the FIFO fill against its trigger. The receive time-out source comes from a counter of bit-time ticks, and its limit is derived from the frame length. The status code and the request line are combinational from the held state, so a status read sees the code of the same cycle. That read can then retire the exact source it reported.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset and whenever no enabled source is pending, `isr_code` reads 6'h01 and `irq` is 0. Otherwise `irq` is 1.
- R2: Codes and fixed priority, highest first: line status 6'h06, receive time-out 6'h0C, receive ready 6'h04, transmit ready 6'h02, modem status 6'h00, Xoff/special character 6'h10, flow-control edge 6'h20. Only the highest pending enabled source is shown, and the others stay queued.
- R3: Any bit of `line_err_stb` sets the line-status source. It is held until `lsr_rd_stb`. A new error in the same cycle as that read keeps it pending.
- R4: Receive ready is pending exactly while `rx_cnt >= rx_trig` and goes away as soon as the count drops below the trigger.
- R5: While `rx_cnt` is non-zero, a counter advances on each `bit_tick`. After 4*`char_bits`+12 ticks with no received character and no receive-data read, the time-out source is set. `rx_char_stb` or `rhr_rd_stb` restarts the count, and only `rhr_rd_stb` clears the source.
- R6: Transmit ready is set when the condition `tx_cnt <= tx_trig` changes from false to true (this includes the FIFO becoming empty). It is cleared by `thr_wr_stb`, or by `isr_rd_stb` in a cycle where `isr_code` is 6'h02. A status read that reports another code leaves it pending. Out of reset the condition is taken as already true.
- R7: Any bit of `modem_delta_stb` sets the modem-status source, and `msr_rd_stb` clears it.
- R8: `xoff_stb` and `special_stb` set two flags shown together as 6'h10. A status read that reports 6'h10 clears both. `xon_stb` also clears the Xoff flag. A received character clears the special flag unless `special_stb` comes in the same cycle.
- R9: `cts_rise_stb` and `rts_rise_stb` set flags that `msr_rd_stb` clears. They are reported (6'h20) only while `enh_en` is 1 and their enable bit is set. An edge latched while `enh_en` is 0 shows once `enh_en` goes to 1.
- R10: Enable bits: `ien[0]` receive ready and time-out, `ien[1]` transmit ready, `ien[2]` line status, `ien[3]` modem status, `ien[5]` Xoff/special, `ien[6]` RTS edge, `ien[7]` CTS edge. A disabled source neither drives `irq` nor `isr_code` but keeps its held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien | input | 8 | Interrupt enable vector |
| enh_en | input | 1 | Enhanced-feature gate for flow-control edge enables |
| rx_cnt | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level |
| tx_cnt | input | CNT_W | Transmit FIFO fill count |
| tx_trig | input | CNT_W | Transmit trigger level |
| char_bits | input | CHAR_W | Frame length in bit times |
| bit_tick | input | 1 | One pulse per bit time |
| rx_char_stb | input | 1 | A character was received |
| rhr_rd_stb | input | 1 | Receive-data register read |
| thr_wr_stb | input | 1 | Transmit-data register write |
| isr_rd_stb | input | 1 | Status register read |
| lsr_rd_stb | input | 1 | Line-status register read |
| msr_rd_stb | input | 1 | Modem-status register read |
| line_err_stb | input | 4 | Line error events |
| modem_delta_stb | input | 4 | Modem-line change events |
| xoff_stb | input | 1 | Xoff character detected |
| xon_stb | input | 1 | Xon character detected |
| special_stb | input | 1 | Special character detected |
| cts_rise_stb | input | 1 | CTS low-to-high under automatic flow control |
| rts_rise_stb | input | 1 | RTS low-to-high under automatic flow control |
| irq | output | 1 | Interrupt request |
| isr_code | output | 6 | Encoded status of the highest pending source |

## Verification
The sharpest same-cycle cases pit a clear against a set. A status read that reports a higher source lands while transmit ready waits below it. A line-status read coincides with a fresh line error. A special character arrives in the very cycle whose received character would clear the previous one. Directed sequences create each of these collisions, and a randomized phase makes many more by firing all strobes at low probability against a wandering FIFO count. A behavioural reference model in the bench predicts the code and request line every cycle, and explicit literal expectations pin the directed corners.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   // priority levels, index 0 is the most urgent
   localparam int unsigned NLVL  = 7;
   localparam int unsigned LV_LS = 0;
   localparam int unsigned LV_TO = 1;
   localparam int unsigned LV_RX = 2;
   localparam int unsigned LV_TX = 3;
   localparam int unsigned LV_MS = 4;
   localparam int unsigned LV_XS = 5;
   localparam int unsigned LV_FC = 6;

   // sticky flag slots
   localparam int unsigned NSF    = 7;
   localparam int unsigned SF_LS  = 0;
   localparam int unsigned SF_TX  = 1;
   localparam int unsigned SF_MS  = 2;
   localparam int unsigned SF_XO  = 3;
   localparam int unsigned SF_SP  = 4;
   localparam int unsigned SF_CTS = 5;
   localparam int unsigned SF_RTS = 6;

   // enable vector bit positions
   localparam int unsigned EN_RX  = 0;
   localparam int unsigned EN_TX  = 1;
   localparam int unsigned EN_LS  = 2;
   localparam int unsigned EN_MS  = 3;
   localparam int unsigned EN_XS  = 5;
   localparam int unsigned EN_RTS = 6;
   localparam int unsigned EN_CTS = 7;

   typedef enum logic [5:0] {
      C_NONE = 6'h01,
      C_LS   = 6'h06,
      C_TO   = 6'h0C,
      C_RX   = 6'h04,
      C_TX   = 6'h02,
      C_MS   = 6'h00,
      C_XS   = 6'h10,
      C_FC   = 6'h20
   } isr_code_e;

   function automatic isr_code_e lvl_code(input int unsigned lvl);
      case (lvl)
         LV_LS:   return C_LS;
         LV_TO:   return C_TO;
         LV_RX:   return C_RX;
         LV_TX:   return C_TX;
         LV_MS:   return C_MS;
         LV_XS:   return C_XS;
         LV_FC:   return C_FC;
         default: return C_NONE;
      endcase
   endfunction

endpackage

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (set[i]) q[i] <= 1'b1;
         else if (clr[i]) q[i] <= 1'b0;
      end

      // R3: a new event beats a same-cycle clear
      a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> q[i]);
      a_r3_clr_only: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !q[i]);
   end

endmodule

// File: rtl/uirq_rx_timer.sv
module uirq_rx_timer #(
   parameter int unsigned CHAR_W = 4,
   parameter int unsigned CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] char_bits,
   input  logic              bit_tick,
   input  logic [CNT_W-1:0]  rx_cnt,
   input  logic              rx_char,
   input  logic              rhr_rd,
   output logic              to_flag
);

   localparam int unsigned TO_MAX = 4 * ((1 << CHAR_W) - 1) + 12;
   localparam int unsigned TO_W   = $clog2(TO_MAX + 1);

   logic [TO_W-1:0] lim;
   logic [TO_W-1:0] cnt;
   logic            restart;

   assign lim     = TO_W'({char_bits, 2'b00}) + TO_W'(12);
   assign restart = rhr_rd || rx_char || (rx_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         to_flag <= 1'b0;
      end else begin
         if (rhr_rd) to_flag <= 1'b0;
         if (restart) begin
            cnt <= '0;
         end else if (bit_tick && !to_flag) begin
            if (cnt == lim - TO_W'(1)) begin
               to_flag <= 1'b1;
               cnt     <= '0;
            end else begin
               cnt <= cnt + TO_W'(1);
            end
         end
      end
   end

   // R5: a receive-data read retires the time-out
   a_r5_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rhr_rd |=> !to_flag);
   // R5: the flag only appears on a tick with data waiting
   a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!to_flag ##1 to_flag) |-> ($past(bit_tick) && $past(rx_cnt) != '0));
   // R5: counter stays within its limit
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < lim || restart);

endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
   import uirq_pkg::*;
#(
   parameter int unsigned N = NLVL
) (
   input  logic [N-1:0] pend,
   output logic [N-1:0] grant,
   output isr_code_e    code,
   output logic         any
);

   always_comb begin
      grant = '0;
      code  = C_NONE;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            code     = lvl_code(unsigned'(i));
         end
      end
   end

   assign any = |pend;

endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
   import uirq_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned CHAR_W     = 4,
   parameter bit          TIMEOUT_EN = 1'b1,
   localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        ien,
   input  logic              enh_en,
   input  logic [CNT_W-1:0]  rx_cnt,
   input  logic [CNT_W-1:0]  rx_trig,
   input  logic [CNT_W-1:0]  tx_cnt,
   input  logic [CNT_W-1:0]  tx_trig,
   input  logic [CHAR_W-1:0] char_bits,
   input  logic              bit_tick,
   input  logic              rx_char_stb,
   input  logic              rhr_rd_stb,
   input  logic              thr_wr_stb,
   input  logic              isr_rd_stb,
   input  logic              lsr_rd_stb,
   input  logic              msr_rd_stb,
   input  logic [3:0]        line_err_stb,
   input  logic [3:0]        modem_delta_stb,
   input  logic              xoff_stb,
   input  logic              xon_stb,
   input  logic              special_stb,
   input  logic              cts_rise_stb,
   input  logic              rts_rise_stb,
   output logic              irq,
   output logic [5:0]        isr_code
);

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("uirq_ctrl: FIFO_DEPTH must be at least 2");
   end
   if (CHAR_W < 2 || CHAR_W > 6) begin : g_bad_char
      $error("uirq_ctrl: CHAR_W must lie in 2..6");
   end

   logic [NSF-1:0]  sf_set, sf_clr, sf_q;
   logic [NLVL-1:0] pend, grant;
   isr_code_e       code;
   logic            any;
   logic            to_flag;
   logic            tx_cond, tx_cond_q, tx_rise;
   logic            hit_tx, hit_xs;

   // transmit room condition and its rising edge
   assign tx_cond = (tx_cnt <= tx_trig);
   assign tx_rise = tx_cond && !tx_cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_cond_q <= 1'b1;
      else        tx_cond_q <= tx_cond;
   end

   // status-read clears apply only to the code shown in that cycle
   assign hit_tx = isr_rd_stb && (code == C_TX);
   assign hit_xs = isr_rd_stb && (code == C_XS);

   always_comb begin
      sf_set         = '0;
      sf_clr         = '0;
      sf_set[SF_LS]  = |line_err_stb;
      sf_clr[SF_LS]  = lsr_rd_stb;
      sf_set[SF_TX]  = tx_rise;
      sf_clr[SF_TX]  = thr_wr_stb || hit_tx;
      sf_set[SF_MS]  = |modem_delta_stb;
      sf_clr[SF_MS]  = msr_rd_stb;
      sf_set[SF_XO]  = xoff_stb;
      sf_clr[SF_XO]  = xon_stb || hit_xs;
      sf_set[SF_SP]  = special_stb;
      sf_clr[SF_SP]  = rx_char_stb || hit_xs;
      sf_set[SF_CTS] = cts_rise_stb;
      sf_clr[SF_CTS] = msr_rd_stb;
      sf_set[SF_RTS] = rts_rise_stb;
      sf_clr[SF_RTS] = msr_rd_stb;
   end

   uirq_sticky #(.N(NSF)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (sf_set),
      .clr   (sf_clr),
      .q     (sf_q)
   );

   if (TIMEOUT_EN) begin : g_to
      uirq_rx_timer #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) u_timer (
         .clk       (clk),
         .rst_n     (rst_n),
         .char_bits (char_bits),
         .bit_tick  (bit_tick),
         .rx_cnt    (rx_cnt),
         .rx_char   (rx_char_stb),
         .rhr_rd    (rhr_rd_stb),
         .to_flag   (to_flag)
      );
   end else begin : g_no_to
      assign to_flag = 1'b0;
   end

   // enable gating; flow-control edges also need the enhanced gate
   always_comb begin
      pend        = '0;
      pend[LV_LS] = sf_q[SF_LS] && ien[EN_LS];
      pend[LV_TO] = to_flag && ien[EN_RX];
      pend[LV_RX] = (rx_cnt >= rx_trig) && ien[EN_RX];
      pend[LV_TX] = sf_q[SF_TX] && ien[EN_TX];
      pend[LV_MS] = sf_q[SF_MS] && ien[EN_MS];
      pend[LV_XS] = (sf_q[SF_XO] || sf_q[SF_SP]) && ien[EN_XS];
      pend[LV_FC] = enh_en && ((sf_q[SF_CTS] && ien[EN_CTS]) ||
                               (sf_q[SF_RTS] && ien[EN_RTS]));
   end

   uirq_prio_enc #(.N(NLVL)) u_enc (
      .pend  (pend),
      .grant (grant),
      .code  (code),
      .any   (any)
   );

   assign irq      = any;
   assign isr_code = code;

   // R1: quiet request line means the idle code
   a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> isr_code == 6'h01);
   // R2: at most one level is granted
   a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R6: a transmit-data write without a new edge retires transmit ready
   a_r6_thr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr_stb && !tx_rise) |=> !sf_q[SF_TX]);
   // R7: modem-status read retires modem and flow-control flags
   a_r7_msr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd_stb && modem_delta_stb == 4'd0 && !cts_rise_stb && !rts_rise_stb)
      |=> !(sf_q[SF_MS] || sf_q[SF_CTS] || sf_q[SF_RTS]));
   // R8: next received character retires the special flag
   a_r8_spec_next_char: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_char_stb && !special_stb) |=> !sf_q[SF_SP]);
   // R9: flow-control code never shows without the enhanced gate
   a_r9_enh_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !enh_en |-> isr_code != 6'h20);

endmodule

// File: tb/uirq_ctrl_tb.sv
`timescale 1ns/1ps
module uirq_ctrl_tb;

   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    ien = 8'h00;
   logic          enh_en = 1'b0;
   logic [CW-1:0] rx_cnt = '0, rx_trig = 6'd8, tx_cnt = '0, tx_trig = 6'd2;
   logic [3:0]    char_bits = 4'd10;
   logic          bit_tick = 1'b0;
   logic          rx_char_stb, rhr_rd_stb, thr_wr_stb, isr_rd_stb, lsr_rd_stb, msr_rd_stb;
   logic [3:0]    line_err_stb, modem_delta_stb;
   logic          xoff_stb, xon_stb, special_stb, cts_rise_stb, rts_rise_stb;
   logic          irq;
   logic [5:0]    isr_code;

   int    n_vec = 0, n_bad = 0;
   string cur_req = "R1";
   bit    finished = 1'b0;

   always #4 clk = ~clk;

   uirq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ien(ien), .enh_en(enh_en),
      .rx_cnt(rx_cnt), .rx_trig(rx_trig), .tx_cnt(tx_cnt), .tx_trig(tx_trig),
      .char_bits(char_bits), .bit_tick(bit_tick),
      .rx_char_stb(rx_char_stb), .rhr_rd_stb(rhr_rd_stb), .thr_wr_stb(thr_wr_stb),
      .isr_rd_stb(isr_rd_stb), .lsr_rd_stb(lsr_rd_stb), .msr_rd_stb(msr_rd_stb),
      .line_err_stb(line_err_stb), .modem_delta_stb(modem_delta_stb),
      .xoff_stb(xoff_stb), .xon_stb(xon_stb), .special_stb(special_stb),
      .cts_rise_stb(cts_rise_stb), .rts_rise_stb(rts_rise_stb),
      .irq(irq), .isr_code(isr_code)
   );

   // ---------------- behavioural reference ----------------
   bit m_ls, m_tx, m_ms, m_xo, m_sp, m_cts, m_rts, m_to, m_prev;
   int m_cnt;

   function automatic logic [5:0] ref_code();
      if (m_ls && ien[2])                          return 6'h06;
      if (m_to && ien[0])                          return 6'h0C;
      if (int'(rx_cnt) >= int'(rx_trig) && ien[0]) return 6'h04;
      if (m_tx && ien[1])                          return 6'h02;
      if (m_ms && ien[3])                          return 6'h00;
      if ((m_xo || m_sp) && ien[5])                return 6'h10;
      if (enh_en && ((m_cts && ien[7]) || (m_rts && ien[6]))) return 6'h20;
      return 6'h01;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      logic [5:0] c;
      bit txc;
      if (!rst_n) begin
         m_ls = 0; m_tx = 0; m_ms = 0; m_xo = 0; m_sp = 0;
         m_cts = 0; m_rts = 0; m_to = 0; m_prev = 1; m_cnt = 0;
      end else begin
         c   = ref_code();
         txc = (int'(tx_cnt) <= int'(tx_trig));
         if (line_err_stb != 0) m_ls = 1; else if (lsr_rd_stb) m_ls = 0;
         if (modem_delta_stb != 0) m_ms = 1; else if (msr_rd_stb) m_ms = 0;
         if (cts_rise_stb) m_cts = 1; else if (msr_rd_stb) m_cts = 0;
         if (rts_rise_stb) m_rts = 1; else if (msr_rd_stb) m_rts = 0;
         if (xoff_stb) m_xo = 1; else if (xon_stb || (isr_rd_stb && c == 6'h10)) m_xo = 0;
         if (special_stb) m_sp = 1; else if (rx_char_stb || (isr_rd_stb && c == 6'h10)) m_sp = 0;
         if (txc && !m_prev) m_tx = 1; else if (thr_wr_stb || (isr_rd_stb && c == 6'h02)) m_tx = 0;
         m_prev = txc;
         if (rhr_rd_stb) m_to = 0;
         if (rhr_rd_stb || rx_char_stb || rx_cnt == 0) m_cnt = 0;
         else if (bit_tick && !m_to) begin
            if (m_cnt == 4 * int'(char_bits) + 11) begin m_to = 1; m_cnt = 0; end
            else m_cnt++;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic clear_stb();
      rx_char_stb = 0; rhr_rd_stb = 0; thr_wr_stb = 0; isr_rd_stb = 0;
      lsr_rd_stb = 0; msr_rd_stb = 0; line_err_stb = 0; modem_delta_stb = 0;
      xoff_stb = 0; xon_stb = 0; special_stb = 0; cts_rise_stb = 0; rts_rise_stb = 0;
   endtask

   task automatic cyc();
      logic [5:0] e;
      @(negedge clk);
      e = ref_code();
      n_vec++;
      if (isr_code !== e || irq !== (e != 6'h01)) begin
         n_bad++;
         $display("FAIL %s model: code=%h irq=%b expected code=%h irq=%b",
                  cur_req, isr_code, irq, e, (e != 6'h01));
      end
      clear_stb();
   endtask

   task automatic expect_code(input logic [5:0] e);
      n_vec++;
      if (isr_code !== e || irq !== (e != 6'h01)) begin
         n_bad++;
         $display("FAIL %s directed: code=%h irq=%b expected code=%h irq=%b",
                  cur_req, isr_code, irq, e, (e != 6'h01));
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      clear_stb();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: idle after reset
      cur_req = "R1";
      cyc(); expect_code(6'h01);

      // R10: disabled source is held but hidden
      cur_req = "R10";
      line_err_stb = 4'b0001; cyc(); expect_code(6'h01);
      ien = 8'hFF; cyc(); expect_code(6'h06);

      // R3: error with read in the same cycle stays pending
      cur_req = "R3";
      line_err_stb = 4'b1000; lsr_rd_stb = 1; cyc(); expect_code(6'h06);
      lsr_rd_stb = 1; cyc(); expect_code(6'h01);

      // R4: level follows fill against trigger
      cur_req = "R4";
      rx_cnt = 6'd8; cyc(); expect_code(6'h04);
      rx_cnt = 6'd7; cyc(); expect_code(6'h01);

      // R5: 4*1+12 = 16 ticks after a restart by a received character
      cur_req = "R5";
      rx_cnt = 6'd1; char_bits = 4'd1; bit_tick = 1;
      repeat (10) cyc();
      rx_char_stb = 1; cyc();
      repeat (15) cyc();
      expect_code(6'h01);
      cyc(); expect_code(6'h0C);
      bit_tick = 0; rhr_rd_stb = 1; cyc(); expect_code(6'h01);
      rx_cnt = 6'd0; cyc();

      // R6: edge set, clear rules, foreign status read
      cur_req = "R6";
      tx_cnt = 6'd5; cyc();
      tx_cnt = 6'd2; cyc(); expect_code(6'h02);
      thr_wr_stb = 1; cyc(); expect_code(6'h01);
      tx_cnt = 6'd5; cyc();
      tx_cnt = 6'd0; cyc(); expect_code(6'h02);
      line_err_stb = 4'b0010; cyc(); expect_code(6'h06);
      isr_rd_stb = 1; cyc(); expect_code(6'h06);
      lsr_rd_stb = 1; cyc(); expect_code(6'h02);
      isr_rd_stb = 1; cyc(); expect_code(6'h01);

      // R7: modem change and its clear
      cur_req = "R7";
      modem_delta_stb = 4'b0100; cyc(); expect_code(6'h00);
      msr_rd_stb = 1; cyc(); expect_code(6'h01);

      // R8: Xoff / special character
      cur_req = "R8";
      xoff_stb = 1; cyc(); expect_code(6'h10);
      xon_stb = 1; cyc(); expect_code(6'h01);
      special_stb = 1; cyc(); expect_code(6'h10);
      rx_char_stb = 1; cyc(); expect_code(6'h01);
      special_stb = 1; rx_char_stb = 1; cyc(); expect_code(6'h10);
      isr_rd_stb = 1; cyc(); expect_code(6'h01);

      // R9: enhanced gate on flow-control edges
      cur_req = "R9";
      enh_en = 0; cts_rise_stb = 1; cyc(); expect_code(6'h01);
      enh_en = 1; cyc(); expect_code(6'h20);
      msr_rd_stb = 1; cyc(); expect_code(6'h01);
      rts_rise_stb = 1; cyc(); expect_code(6'h20);
      msr_rd_stb = 1; cyc(); expect_code(6'h01);

      // R2: stacked sources drain in priority order
      cur_req = "R2";
      tx_cnt = 6'd5; rts_rise_stb = 1; xoff_stb = 1; modem_delta_stb = 4'b0001; cyc();
      tx_cnt = 6'd0; rx_cnt = 6'd8; line_err_stb = 4'b0100; cyc(); expect_code(6'h06);
      lsr_rd_stb = 1; cyc(); expect_code(6'h04);
      rx_cnt = 6'd3; cyc(); expect_code(6'h02);
      thr_wr_stb = 1; cyc(); expect_code(6'h00);
      msr_rd_stb = 1; cyc(); expect_code(6'h10);
      isr_rd_stb = 1; cyc(); expect_code(6'h01);
      rx_cnt = 6'd8; char_bits = 4'd0; bit_tick = 1;
      repeat (12) cyc();
      expect_code(6'h0C);
      bit_tick = 0; rhr_rd_stb = 1; cyc(); expect_code(6'h04);
      rx_cnt = 6'd0; cyc(); expect_code(6'h01);

      // R2: randomized collisions checked against the model every cycle
      for (int k = 0; k < 6000; k++) begin
         bit_tick = ($urandom_range(0, 1) == 1);
         if ($urandom_range(0, 200) == 0) ien = 8'($urandom);
         if ($urandom_range(0, 300) == 0) enh_en = ~enh_en;
         if ($urandom_range(0, 7) == 0) begin
            if ($urandom_range(0, 1) == 1 && rx_cnt < 6'd32) rx_cnt = rx_cnt + 6'd1;
            else if (rx_cnt > 6'd0) rx_cnt = rx_cnt - 6'd1;
         end
         if ($urandom_range(0, 9) == 0) tx_cnt = 6'($urandom_range(0, 6));
         if ($urandom_range(0, 500) == 0) char_bits = 4'($urandom_range(0, 3));
         rx_char_stb     = ($urandom_range(0, 20) == 0);
         rhr_rd_stb      = ($urandom_range(0, 30) == 0);
         thr_wr_stb      = ($urandom_range(0, 20) == 0);
         isr_rd_stb      = ($urandom_range(0, 6) == 0);
         lsr_rd_stb      = ($urandom_range(0, 15) == 0);
         msr_rd_stb      = ($urandom_range(0, 15) == 0);
         line_err_stb    = ($urandom_range(0, 25) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
         modem_delta_stb = ($urandom_range(0, 25) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
         xoff_stb        = ($urandom_range(0, 30) == 0);
         xon_stb         = ($urandom_range(0, 30) == 0);
         special_stb     = ($urandom_range(0, 30) == 0);
         cts_rise_stb    = ($urandom_range(0, 40) == 0);
         rts_rise_stb    = ($urandom_range(0, 40) == 0);
         cyc();
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule